// File: doc/BRIEF.md
# Low-Power PWM Timer with Register Interface

This block is a single-channel pulse-width modulation timer placed behind a simple word-addressed register bus. Software programs a power-of-two prescaler exponent and an output polarity while the timer is stopped. It then enables the timer, loads a 16-bit reload value and a 16-bit compare value, and sets a start bit. From that point the counter runs continuously from the prescaled clock. It counts from 0 up to the reload value, returns to 0, and drives one PWM output whose active phase is the part of each period in which the count is above the compare value.

Writes are accepted only in certain states. Configuration writes take effect only while the timer is disabled. Reload and compare writes take effect only while it is enabled. Each accepted reload or compare write raises its own completion flag a fixed two cycles later. Software waits for that flag and clears it through a separate clear register. Reload and compare values written while the counter runs are held back until the period in progress ends.

Top module: `lp_pwm_timer`

## Requirements
- R1: After reset every register reads 0, both status flags are 0 and `pwm_out` is 0.
- R2: The configuration register sits at offset 0x4, with the prescaler exponent in bits 2:0 and the polarity in bit 3. A write to it while the enable bit is set changes nothing. A write while the timer is disabled is stored and read back.
- R3: The reload register (offset 0x8) and the compare register (offset 0xC) are 16 bits wide. A write to either while the timer is disabled changes neither the register nor any status flag.
- R4: The status register sits at offset 0x10, with the compare flag in bit 0 and the reload flag in bit 1. After an accepted write, the matching flag still reads 0 in the cycle right after the write edge and reads 1 from the following cycle on.
- R5: Writing 1 to bit 0 or bit 1 of the clear register (offset 0x14) clears only the matching flag. If a completion reaches a flag in the same cycle as its clear, the flag stays set.
- R6: The control register sits at offset 0x0, with enable in bit 0 and start in bit 2. Start is taken only together with enable. A running counter counts 0..reload and wraps, so one period lasts (reload+1)·2^exponent clock cycles.
- R7: The output is active while count > compare, which gives (reload−compare)·2^exponent active cycles per period, or none when compare ≥ reload. `pwm_out` equals the active state XOR the polarity bit.
- R8: While the counter runs, new reload and compare values take effect only at the next wrap. While the timer is enabled but not started, they take effect at once.
- R9: Writing the control register with bit 0 clear stops the counter, clears the start bit and returns `pwm_out` to the polarity level. A later start begins again from count 0.
- R10: While the timer is enabled but not started, `pwm_out` stays at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus and the counter |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 5 | Byte offset of the register for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | 1 | PWM waveform after polarity |

## Verification
Two functions can act on the reload flag in the same clock edge: a completion coming out of the two-stage flag pipeline, and a software write to the clear register. The bench provokes this by writing the reload register and then, on the very next edge, writing the clear bit. At that edge the pending completion lands together with the clear. The status register must then still show the flag set, while a second clear with nothing pending must drop it. A second overlap is tested as well: a compare write made in the middle of a running period. It is judged by sampling the output at fixed counts in that period and in the next one.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int OFS_CTRL  = 'h00;
  localparam int OFS_CFG   = 'h04;
  localparam int OFS_RLD   = 'h08;
  localparam int OFS_CMP   = 'h0C;
  localparam int OFS_STAT  = 'h10;
  localparam int OFS_CLR   = 'h14;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_START_BIT = 2;
  localparam int STAT_CMP_BIT   = 0;
  localparam int STAT_RLD_BIT   = 1;

  // clock cycles per counter step for a given prescaler exponent
  function automatic int unsigned step_len(input int unsigned expo);
    return 32'd1 << expo;
  endfunction

  // active decision: strictly above the compare value
  function automatic logic above_cmp(input int unsigned count, input int unsigned cmp);
    return count > cmp;
  endfunction
endpackage

// File: rtl/lpt_regs.sv
module lpt_regs
  import lpt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              en,
  output logic              run,
  output logic [PRE_W-1:0]  presc,
  output logic              pol,
  output logic [CNT_W-1:0]  arr_q,
  output logic [CNT_W-1:0]  cmp_q,
  output logic              arr_acc,
  output logic              cmp_acc,
  output logic              arr_ok,
  output logic              cmp_ok,
  output logic              clr_arr,
  output logic              clr_cmp
);
  localparam int POL_BIT = PRE_W;

  logic sel_ctrl, sel_cfg, sel_rld, sel_cmp, sel_clr;
  logic arr_pipe, cmp_pipe;
  logic unused_wdata;

  assign sel_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign sel_cfg  = bus_wr && (bus_addr == ADDR_W'(OFS_CFG));
  assign sel_rld  = bus_wr && (bus_addr == ADDR_W'(OFS_RLD));
  assign sel_cmp  = bus_wr && (bus_addr == ADDR_W'(OFS_CMP));
  assign sel_clr  = bus_wr && (bus_addr == ADDR_W'(OFS_CLR));

  assign arr_acc  = sel_rld && en;
  assign cmp_acc  = sel_cmp && en;
  assign clr_arr  = sel_clr && bus_wdata[STAT_RLD_BIT];
  assign clr_cmp  = sel_clr && bus_wdata[STAT_CMP_BIT];
  assign unused_wdata = ^bus_wdata[DATA_W-1:CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; run <= 1'b0; presc <= '0; pol <= 1'b0;
      arr_q <= '0; cmp_q <= '0;
      arr_pipe <= 1'b0; cmp_pipe <= 1'b0;
      arr_ok <= 1'b0; cmp_ok <= 1'b0;
    end else begin
      if (sel_ctrl) begin
        en  <= bus_wdata[CTRL_EN_BIT];
        run <= bus_wdata[CTRL_EN_BIT] & (bus_wdata[CTRL_START_BIT] | run);
      end
      if (sel_cfg && !en) begin
        presc <= bus_wdata[PRE_W-1:0];
        pol   <= bus_wdata[POL_BIT];
      end
      if (arr_acc) arr_q <= bus_wdata[CNT_W-1:0];
      if (cmp_acc) cmp_q <= bus_wdata[CNT_W-1:0];
      arr_pipe <= arr_acc;
      cmp_pipe <= cmp_acc;
      // a completion in flight wins over a clear in the same cycle
      arr_ok <= arr_pipe | (arr_ok & ~clr_arr);
      cmp_ok <= cmp_pipe | (cmp_ok & ~clr_cmp);
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFS_CTRL): begin
        bus_rdata[CTRL_EN_BIT]    = en;
        bus_rdata[CTRL_START_BIT] = run;
      end
      ADDR_W'(OFS_CFG): begin
        bus_rdata[PRE_W-1:0] = presc;
        bus_rdata[POL_BIT]   = pol;
      end
      ADDR_W'(OFS_RLD): bus_rdata[CNT_W-1:0] = arr_q;
      ADDR_W'(OFS_CMP): bus_rdata[CNT_W-1:0] = cmp_q;
      ADDR_W'(OFS_STAT): begin
        bus_rdata[STAT_RLD_BIT] = arr_ok;
        bus_rdata[STAT_CMP_BIT] = cmp_ok;
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/lpt_counter.sv
module lpt_counter
  import lpt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] presc,
  input  logic [CNT_W-1:0] arr_q,
  input  logic [CNT_W-1:0] cmp_q,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] arr_act,
  output logic [CNT_W-1:0] cmp_act,
  output logic             tick,
  output logic             wrap
);
  localparam int DIV_W = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] div;
  logic             step_end;

  assign step_end = (div == DIV_W'(step_len(32'(presc)) - 1));
  assign tick     = run && step_end;
  assign wrap     = tick && (cnt >= arr_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div <= '0; cnt <= '0; arr_act <= '0; cmp_act <= '0;
    end else if (!run) begin
      div     <= '0;
      cnt     <= '0;
      arr_act <= arr_q;
      cmp_act <= cmp_q;
    end else begin
      div <= step_end ? '0 : div + DIV_W'(1);
      if (wrap) begin
        cnt     <= '0;
        arr_act <= arr_q;
        cmp_act <= cmp_q;
      end else if (tick) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/lpt_output.sv
module lpt_output
  import lpt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             run,
  input  logic             pol,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp_act,
  output logic             active,
  output logic             pwm_out
);
  assign active  = run && above_cmp(32'(cnt), 32'(cmp_act));
  assign pwm_out = active ^ pol;
endmodule

// File: rtl/lp_pwm_timer.sv
module lp_pwm_timer #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_out
);
  logic             en, run, pol;
  logic [PRE_W-1:0] presc;
  logic [CNT_W-1:0] arr_q, cmp_q, arr_act, cmp_act, cnt;
  logic             arr_acc, cmp_acc, arr_ok, cmp_ok, clr_arr, clr_cmp;
  logic             tick, wrap, active;

  lpt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PRE_W(PRE_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .en(en), .run(run), .presc(presc), .pol(pol), .arr_q(arr_q), .cmp_q(cmp_q),
    .arr_acc(arr_acc), .cmp_acc(cmp_acc), .arr_ok(arr_ok), .cmp_ok(cmp_ok),
    .clr_arr(clr_arr), .clr_cmp(clr_cmp)
  );

  lpt_counter #(.CNT_W(CNT_W), .PRE_W(PRE_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .run(run), .presc(presc),
    .arr_q(arr_q), .cmp_q(cmp_q), .cnt(cnt), .arr_act(arr_act),
    .cmp_act(cmp_act), .tick(tick), .wrap(wrap)
  );

  lpt_output #(.CNT_W(CNT_W)) out_i (
    .run(run), .pol(pol), .cnt(cnt), .cmp_act(cmp_act),
    .active(active), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/lpt_checker.sv
module lpt_checker #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             run,
  input logic [PRE_W-1:0] presc,
  input logic             pol,
  input logic [CNT_W-1:0] arr_q,
  input logic [CNT_W-1:0] cmp_q,
  input logic [CNT_W-1:0] arr_act,
  input logic [CNT_W-1:0] cnt,
  input logic             wrap,
  input logic             arr_acc,
  input logic             arr_ok,
  input logic             cmp_ok,
  input logic             clr_arr,
  input logic             clr_cmp,
  input logic             pwm_out
);
  a_r2_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) |-> ($stable(presc) && $stable(pol)));

  a_r3_values_frozen_off: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> ($stable(arr_q) && $stable(cmp_q)));

  a_r4_flag_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arr_ok) |-> $past(arr_acc, 2));

  a_r5_rld_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_ok && !clr_arr) |=> arr_ok);

  a_r5_cmp_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_ok && !clr_cmp) |=> cmp_ok);

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= arr_act));

  a_r8_reload_deferred: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(arr_act));

  a_r9_stop_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

  a_r9_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (pwm_out == pol));
endmodule

bind lp_pwm_timer lpt_checker #(.CNT_W(CNT_W), .PRE_W(PRE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .run(run), .presc(presc), .pol(pol),
  .arr_q(arr_q), .cmp_q(cmp_q), .arr_act(arr_act), .cnt(cnt), .wrap(wrap),
  .arr_acc(arr_acc), .arr_ok(arr_ok), .cmp_ok(cmp_ok),
  .clr_arr(clr_arr), .clr_cmp(clr_cmp), .pwm_out(pwm_out)
);

// File: tb/lp_pwm_timer_tb_top.sv
`timescale 1ns/1ps
module lp_pwm_timer_tb_top;
  localparam int A_CTRL = 'h00, A_CFG = 'h04, A_RLD = 'h08, A_CMP = 'h0C;
  localparam int A_STAT = 'h10, A_CLR = 'h14;
  localparam int NVEC = 8;
  // {exponent, polarity, reload, compare, period cycles, active cycles per period}
  localparam logic [67:0] VEC [NVEC] = '{
    {3'd0, 1'b0, 16'd9, 16'd4, 16'd10,  16'd5},
    {3'd1, 1'b1, 16'd7, 16'd2, 16'd16,  16'd10},
    {3'd2, 1'b0, 16'd3, 16'd0, 16'd16,  16'd12},
    {3'd0, 1'b0, 16'd5, 16'd5, 16'd6,   16'd0},
    {3'd0, 1'b1, 16'd4, 16'd9, 16'd5,   16'd0},
    {3'd3, 1'b0, 16'd2, 16'd1, 16'd24,  16'd8},
    {3'd7, 1'b0, 16'd1, 16'd0, 16'd256, 16'd128},
    {3'd0, 1'b0, 16'd0, 16'd0, 16'd1,   16'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwm_out;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  lp_pwm_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge; returns at the next negedge
  task automatic wr(input int a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    bus_addr = 5'(a);
    #1;
    v = bus_rdata;
  endtask

  task automatic measure(input int n, input logic p, output int act);
    act = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_out != p) act++;
      @(negedge clk);
    end
  endtask

  task automatic skip(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int act;
    skip(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CTRL, v); check(v == 0, "R1 ctrl", v, 0);
    rd(A_CFG, v);  check(v == 0, "R1 cfg", v, 0);
    rd(A_STAT, v); check(v == 0, "R1 status", v, 0);
    check(pwm_out == 1'b0, "R1 pwm_out", pwm_out, 0);

    // R3 reload/compare writes ignored while disabled
    wr(A_RLD, 32'h55); wr(A_CMP, 32'h33); skip(2);
    rd(A_RLD, v);  check(v == 0, "R3 reload ignored", v, 0);
    rd(A_CMP, v);  check(v == 0, "R3 compare ignored", v, 0);
    rd(A_STAT, v); check(v == 0, "R3 no flag", v, 0);

    // R6 start without enable is not taken
    wr(A_CTRL, 32'h4);
    rd(A_CTRL, v); check(v == 0, "R6 start needs enable", v, 0);

    // R2 configuration locked while enabled
    wr(A_CTRL, 32'h1);
    wr(A_CFG, 32'hF);
    rd(A_CFG, v); check(v == 0, "R2 cfg ignored when enabled", v, 0);

    // R4 reload flag timing, compare flag
    wr(A_RLD, 32'd3);
    rd(A_STAT, v); check(v[1] == 1'b0, "R4 reload flag first cycle", v[1], 0);
    @(negedge clk);
    rd(A_STAT, v); check(v[1] == 1'b1, "R4 reload flag second cycle", v[1], 1);
    wr(A_CMP, 32'd0); skip(1);
    rd(A_STAT, v); check(v == 32'h3, "R4 both flags", v, 3);

    // R10 enabled, not started: output inactive
    measure(20, 1'b0, act); check(act == 0, "R10 idle output", act, 0);

    // R5 individual clear and set-wins overlap
    wr(A_CLR, 32'h1);
    rd(A_STAT, v); check(v == 32'h2, "R5 clear compare only", v, 2);
    wr(A_RLD, 32'd3);
    wr(A_CLR, 32'h2);
    rd(A_STAT, v); check(v[1] == 1'b1, "R5 set wins over clear", v[1], 1);
    wr(A_CLR, 32'h2);
    rd(A_STAT, v); check(v[1] == 1'b0, "R5 clear reload", v[1], 0);

    // R2 configuration accepted while disabled
    wr(A_CTRL, 32'h0);
    wr(A_CFG, 32'hB);
    rd(A_CFG, v); check(v == 32'hB, "R2 cfg accepted when disabled", v, 'hB);

    // R6 R7 vector table
    for (int i = 0; i < NVEC; i++) begin
      logic [67:0] t;
      t = VEC[i];
      wr(A_CTRL, 32'h0);
      wr(A_CFG, {28'd0, t[64], t[67:65]});
      wr(A_CTRL, 32'h1);
      wr(A_RLD, {16'd0, t[63:48]});
      wr(A_CMP, {16'd0, t[47:32]});
      wr(A_CTRL, 32'h5);
      measure(2 * int'(t[31:16]), t[64], act);
      check(act == 2 * int'(t[15:0]), $sformatf("R7 vector %0d active cycles", i),
            act, 2 * int'(t[15:0]));
      rd(A_CTRL, v); check(v == 32'h5, "R6 running ctrl", v, 5);
    end

    // R8 compare written mid-period waits for the wrap
    wr(A_CTRL, 32'h0);
    wr(A_CFG, 32'h0);
    wr(A_CTRL, 32'h1);
    wr(A_RLD, 32'd9);
    wr(A_CMP, 32'd4);
    wr(A_CTRL, 32'h5);        // count 0 now
    @(negedge clk);           // count 1
    wr(A_CMP, 32'd8);         // count 2
    skip(3);                  // count 5
    check(pwm_out == 1'b1, "R8 old compare holds", pwm_out, 1);
    skip(10);                 // count 5, next period
    check(pwm_out == 1'b0, "R8 new compare after wrap", pwm_out, 0);
    skip(4);                  // count 9
    check(pwm_out == 1'b1, "R8 new compare active", pwm_out, 1);

    // R9 stop, inactive level, restart from zero
    wr(A_CTRL, 32'h0);
    check(pwm_out == 1'b0, "R9 stopped output", pwm_out, 0);
    rd(A_CTRL, v); check(v == 0, "R9 start cleared", v, 0);
    wr(A_CFG, 32'h8);
    check(pwm_out == 1'b1, "R9 inactive level with polarity", pwm_out, 1);
    wr(A_CTRL, 32'h1);
    wr(A_CTRL, 32'h5);        // count 0
    check(pwm_out == 1'b1, "R9 restart count 0", pwm_out, 1);
    skip(9);                  // count 9
    check(pwm_out == 1'b0, "R9 restart count 9 active", pwm_out, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule